// File: doc/BRIEF.md
# Line-Doubling Upscaler Output Sequencer

This controller drives the read side of a 2x bilinear upscaler that keeps two image lines in its buffer. It watches input pixel strobes, keeps the write column for the line buffer, and starts output once a complete input line has been stored. From then on it emits one output pixel per clock, which is four times the input pixel rate. Output rows alternate between two phases. In the even phase, stored pixels alternate with horizontal midpoints. In the odd phase, vertical midpoints alternate with centre (four-pixel) averages taken between two stored lines.

For every output pixel the sequencer gives the output column and row, an interpolation mode, and two edge flags. The flags tell the datapath to copy the neighbouring pixel instead of interpolating past the picture edge. The last-column flag also serves as the end-of-line marker. A start-of-frame marker comes with the first pixel of each frame. After the last output row of a frame, the sequencer waits for the next frame's first line. Any input lines that arrived early are counted, so none are lost.

Top module: `upscale_seq_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, out_valid, sof, bnd_col and bnd_row are 0, and wr_col is 0.
- R2: No output pixel appears before input line 0 of a frame is complete. The first pixel appears two clock edges after the edge that captures the last pixel of that line.
- R3: Each output row is 2*IN_COLS consecutive valid cycles, with out_col counting up from 0 to 2*IN_COLS-1.
- R4: out_mode encodes the interpolation type. In even rows, an even column gives 0 (stored pixel) and an odd column gives 1 (horizontal). In odd rows, an even column gives 2 (vertical) and an odd column gives 3 (centre).
- R5: Even output row 2k starts only after input line k has been stored. Odd row 2k+1 follows on the cycle right after row 2k ends.
- R6: bnd_col is 1 exactly on the valid cycle with out_col = 2*IN_COLS-1, and it marks the end of the line.
- R7: bnd_row is 1 on every valid cycle of output row 2*IN_ROWS-1 and on no other cycle.
- R8: sof is 1 only on the valid cycle with out_row = 0 and out_col = 0.
- R9: After the last output row, output stops until a completed first line of the next frame is available. Lines completed early are counted and used in order, so each frame yields exactly 4*IN_COLS*IN_ROWS pixels.
- R10: wr_col counts accepted input pixels from 0 to IN_COLS-1 and wraps to 0 after the last pixel of a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | One input pixel accepted this cycle |
| wr_col | output | $clog2(IN_COLS) | Line-buffer write column of the current input pixel |
| out_valid | output | 1 | An output pixel is produced this cycle |
| out_mode | output | 2 | Interpolation type: 0 stored, 1 horizontal, 2 vertical, 3 centre |
| out_col | output | $clog2(2*IN_COLS) | Output column |
| out_row | output | $clog2(2*IN_ROWS) | Output row |
| bnd_col | output | 1 | Last output column: copy edge pixel; end of line |
| bnd_row | output | 1 | Last output row: copy previous line |
| sof | output | 1 | First pixel of a frame |

## Verification
The bench feeds input at the nominal quarter rate, at a slower rate that forces waits between row pairs, and in bursts where the next frame's first line completes while the current frame's last rows are still being emitted. A sequencer that ignored the stored-line count would either start rows before their data exists or, in the burst case, drop or repeat a line. Either error shows up as wrong start cycles and a wrong pixel count per frame. Off-by-one errors in the row or column limits would show up as edge flags or end-of-line markers on the wrong pixel, and a swapped parity would give the wrong interpolation mode on every pixel.

// File: rtl/upx_pkg.sv
package upx_pkg;
  typedef enum logic [1:0] {
    MODE_ORIG = 2'd0,
    MODE_HORZ = 2'd1,
    MODE_VERT = 2'd2,
    MODE_CENT = 2'd3
  } upx_mode_e;

  typedef enum logic [1:0] {
    PH_WAIT = 2'd0,
    PH_EVEN = 2'd1,
    PH_ODD  = 2'd2
  } upx_phase_e;
endpackage

// File: rtl/upx_in_count.sv
module upx_in_count #(
  parameter int IN_COLS  = 20,
  parameter int IN_COL_W = $clog2(IN_COLS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic [IN_COL_W-1:0] wr_col,
  output logic                line_done
);
  localparam logic [IN_COL_W-1:0] LAST_IN = IN_COL_W'(IN_COLS - 1);

  always_ff @(posedge clk) begin
    if (rst)
      wr_col <= '0;
    else if (in_valid)
      wr_col <= (wr_col == LAST_IN) ? '0 : wr_col + 1'b1;
  end

  assign line_done = in_valid && (wr_col == LAST_IN);

  AST_WR_WRAP: assert property (@(posedge clk) disable iff (rst)
    line_done |=> wr_col == '0); // R10
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(wr_col)); // R10
endmodule

// File: rtl/upx_seq.sv
module upx_seq
  import upx_pkg::*;
#(
  parameter int OUT_COLS = 40,
  parameter int OUT_ROWS = 8,
  parameter int COL_W    = $clog2(OUT_COLS),
  parameter int ROW_W    = $clog2(OUT_ROWS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_done,
  output upx_phase_e       phase,
  output logic [COL_W-1:0] col,
  output logic [ROW_W-1:0] row
);
  localparam int RDY_W = 2;
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(OUT_COLS - 1);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(OUT_ROWS - 1);
  localparam logic [RDY_W-1:0] RDY_MAX  = '1;

  logic [RDY_W-1:0] ready;
  logic             row_end;
  logic             take;

  assign row_end = (col == LAST_COL);
  assign take = (ready != '0) &&
                ((phase == PH_WAIT) || (phase == PH_ODD && row_end));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_WAIT;
      col   <= '0;
      row   <= '0;
      ready <= '0;
    end else begin
      ready <= ready + RDY_W'(line_done) - RDY_W'(take);
      case (phase)
        PH_WAIT: begin
          if (take) begin
            phase <= PH_EVEN;
            col   <= '0;
          end
        end
        PH_EVEN: begin
          if (row_end) begin
            phase <= PH_ODD;
            col   <= '0;
            row   <= row + 1'b1;
          end else begin
            col <= col + 1'b1;
          end
        end
        PH_ODD: begin
          if (row_end) begin
            col   <= '0;
            row   <= (row == LAST_ROW) ? '0 : row + 1'b1;
            phase <= take ? PH_EVEN : PH_WAIT;
          end else begin
            col <= col + 1'b1;
          end
        end
        default: phase <= PH_WAIT;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    !(ready == RDY_MAX && line_done && !take)); // R9
  AST_START_GATED: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_EVEN && $past(phase) != PH_EVEN) |-> $past(ready) != '0 || $past(phase) == PH_ODD); // R5
  AST_EVEN_PARITY: assert property (@(posedge clk) disable iff (rst)
    phase == PH_EVEN |-> row[0] == 1'b0); // R4
  AST_ODD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_EVEN && row_end) |=> phase == PH_ODD && col == '0); // R5
endmodule

// File: rtl/upx_decode.sv
module upx_decode
  import upx_pkg::*;
#(
  parameter int OUT_COLS = 40,
  parameter int OUT_ROWS = 8,
  parameter int COL_W    = $clog2(OUT_COLS),
  parameter int ROW_W    = $clog2(OUT_ROWS)
) (
  input  logic             clk,
  input  logic             rst,
  input  upx_phase_e       phase,
  input  logic [COL_W-1:0] col,
  input  logic [ROW_W-1:0] row,
  output logic             out_valid,
  output upx_mode_e        out_mode,
  output logic [COL_W-1:0] out_col,
  output logic [ROW_W-1:0] out_row,
  output logic             bnd_col,
  output logic             bnd_row,
  output logic             sof
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(OUT_COLS - 1);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(OUT_ROWS - 1);

  logic active;
  assign active = (phase != PH_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_mode  <= MODE_ORIG;
      out_col   <= '0;
      out_row   <= '0;
      bnd_col   <= 1'b0;
      bnd_row   <= 1'b0;
      sof       <= 1'b0;
    end else begin
      out_valid <= active;
      out_mode  <= upx_mode_e'({row[0], col[0]});
      out_col   <= col;
      out_row   <= row;
      bnd_col   <= active && (col == LAST_COL);
      bnd_row   <= active && (row == LAST_ROW);
      sof       <= active && (col == '0) && (row == '0);
    end
  end

  AST_COL_STEP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !bnd_col) |=> out_valid && out_col == $past(out_col) + 1'b1); // R3
  AST_EDGE_COL: assert property (@(posedge clk) disable iff (rst)
    bnd_col |=> !out_valid || out_col == '0); // R6
  AST_EDGE_ROW: assert property (@(posedge clk) disable iff (rst)
    bnd_row |-> out_valid && out_row[0]); // R7
  AST_SOF_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    sof |-> out_valid && out_mode == MODE_ORIG); // R8
endmodule

// File: rtl/upscale_seq_ctrl.sv
module upscale_seq_ctrl
  import upx_pkg::*;
#(
  parameter int IN_COLS  = 20,
  parameter int IN_ROWS  = 4,
  parameter int OUT_COLS = 2 * IN_COLS,
  parameter int OUT_ROWS = 2 * IN_ROWS,
  parameter int IN_COL_W = $clog2(IN_COLS),
  parameter int COL_W    = $clog2(OUT_COLS),
  parameter int ROW_W    = $clog2(OUT_ROWS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic [IN_COL_W-1:0] wr_col,
  output logic                out_valid,
  output logic [1:0]          out_mode,
  output logic [COL_W-1:0]    out_col,
  output logic [ROW_W-1:0]    out_row,
  output logic                bnd_col,
  output logic                bnd_row,
  output logic                sof
);
  logic             line_done;
  upx_phase_e       phase;
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;
  upx_mode_e        mode_q;

  upx_in_count #(.IN_COLS(IN_COLS), .IN_COL_W(IN_COL_W)) u_in (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .wr_col(wr_col), .line_done(line_done)
  );

  upx_seq #(.OUT_COLS(OUT_COLS), .OUT_ROWS(OUT_ROWS),
            .COL_W(COL_W), .ROW_W(ROW_W)) u_seq (
    .clk(clk), .rst(rst), .line_done(line_done),
    .phase(phase), .col(col), .row(row)
  );

  upx_decode #(.OUT_COLS(OUT_COLS), .OUT_ROWS(OUT_ROWS),
               .COL_W(COL_W), .ROW_W(ROW_W)) u_dec (
    .clk(clk), .rst(rst), .phase(phase), .col(col), .row(row),
    .out_valid(out_valid), .out_mode(mode_q), .out_col(out_col),
    .out_row(out_row), .bnd_col(bnd_col), .bnd_row(bnd_row), .sof(sof)
  );

  assign out_mode = mode_q;
endmodule

// File: tb/test_upscale_seq_ctrl.sv
`timescale 1ns/1ps
module test_upscale_seq_ctrl;
  localparam int W  = 5;
  localparam int H  = 3;
  localparam int IW = $clog2(W);
  localparam int CW = $clog2(2 * W);
  localparam int RW = $clog2(2 * H);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [IW-1:0] wr_col;
  logic out_valid, bnd_col, bnd_row, sof;
  logic [1:0] out_mode;
  logic [CW-1:0] out_col;
  logic [RW-1:0] out_row;

  always #2.5 clk = ~clk;

  upscale_seq_ctrl #(.IN_COLS(W), .IN_ROWS(H)) i_upscale_seq_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .wr_col(wr_col),
    .out_valid(out_valid), .out_mode(out_mode), .out_col(out_col),
    .out_row(out_row), .bnd_col(bnd_col), .bnd_row(bnd_row), .sof(sof)
  );

  int n_cmp = 0, n_bad = 0;
  int n_pix = 0, cycles = 0;

  // behavioural reference: line tokens waiting, output raster position
  int lines_q[$];
  int m_wc, m_busy, m_row, m_col, m_frame_line;
  int e_valid, e_mode, e_col, e_row, e_bc, e_br, e_sof, e_wc;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      lines_q.delete();
      m_wc = 0; m_busy = 0; m_row = 0; m_col = 0; m_frame_line = 0;
      e_valid = 0; e_mode = 0; e_col = 0; e_row = 0;
      e_bc = 0; e_br = 0; e_sof = 0; e_wc = 0;
    end else begin
      // outputs visible after this edge reflect the raster position before it
      e_valid = m_busy;
      e_col   = m_busy ? m_col : 0;
      e_row   = m_row;
      e_mode  = (m_row % 2) * 2 + (m_col % 2);
      e_bc    = m_busy && (m_col == 2 * W - 1);
      e_br    = m_busy && (m_row == 2 * H - 1);
      e_sof   = m_busy && (m_col == 0) && (m_row == 0);
      // raster advance, using the stored-line tokens present before this edge
      if (m_busy) begin
        if (m_col == 2 * W - 1) begin
          m_col = 0;
          if (m_row % 2 == 0) m_row++;
          else begin
            m_row = (m_row == 2 * H - 1) ? 0 : m_row + 1;
            if (lines_q.size() > 0) void'(lines_q.pop_front());
            else m_busy = 0;
          end
        end else m_col++;
      end else if (lines_q.size() > 0) begin
        void'(lines_q.pop_front());
        m_busy = 1;
        m_col = 0;
      end
      if (in_valid) begin
        if (m_wc == W - 1) begin
          m_wc = 0;
          lines_q.push_back(m_frame_line);
          m_frame_line = (m_frame_line + 1) % H;
        end else m_wc++;
      end
      e_wc = m_wc;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R2/R5 out_valid", out_valid, e_valid);
      chk("R10 wr_col", wr_col, e_wc);
      chk("R6 bnd_col", bnd_col, e_bc);
      chk("R7 bnd_row", bnd_row, e_br);
      chk("R8 sof", sof, e_sof);
      if (e_valid) begin
        n_pix++;
        chk("R3 out_col", out_col, e_col);
        chk("R5 out_row", out_row, e_row);
        chk("R4 out_mode", out_mode, e_mode);
      end
    end
  end

  task automatic feed_line(int gap);
    for (int p = 0; p < W; p++) begin
      @(negedge clk); in_valid = 1'b1;
      @(negedge clk); in_valid = 1'b0;
      for (int g = 1; g < gap; g++) @(negedge clk);
    end
  endtask

  task automatic feed_frame(int gap, int pause);
    for (int l = 0; l < H; l++) begin
      feed_line(gap);
      for (int q = 0; q < pause; q++) @(negedge clk);
    end
  endtask

  task automatic drain();
    for (int q = 0; q < 8 * W * H + 40; q++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs while reset is held
    chk("R1 out_valid", out_valid, 0);
    chk("R1 sof", sof, 0);
    chk("R1 bnd_col", bnd_col, 0);
    chk("R1 bnd_row", bnd_row, 0);
    chk("R1 wr_col", wr_col, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 out_valid after reset", out_valid, 0);
    // nominal quarter rate (one pixel per four clocks, pulse plus three idle)
    feed_frame(3, 0);
    drain();
    // slow input: rows wait for their lines
    feed_frame(8, 5);
    drain();
    // bursts, two frames back to back: next frame's line 0 lands early
    feed_frame(1, 3 * W);
    feed_frame(1, 3 * W);
    drain();
    chk("R9 total pixels over four frames", n_pix, 4 * 4 * W * H);
    chk("R9 idle after last frame", out_valid, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 50000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule